// File: doc/BRIEF.md
# Serial Port Control Register File

This block is the register file in front of a FIFO-capable serial port. A host reaches it through a single-cycle bus: a byte offset, a read strobe, a write strobe and 16 bits of write data. The offset window is 0x28 bytes. The block stores the mode, bit-rate, control, FIFO-control and port registers. It also keeps five transmit and receive status flags.

Each accepted write to the transmit data offset sends the low byte to a transmit output as a one-cycle valid pulse. That output feeds the serial engine, which sits outside this block.

A mode input selects between two modes:
- FIFO mode narrows the mode and control write masks and exposes the status, FIFO-control, count, port and line-status offsets.
- Plain mode stores full bytes and exposes only the four base registers.

Read data and the error pulse are registered. Both appear on the clock edge after the access.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the outputs are idle and the registers hold these values: rate register 0xFF, mode, control, port and FIFO control all 0, status flags transmit-end and transmit-empty set and the rest clear (status reads 0x0060), data register 0xFF.
- R2: The offsets are mode 0x00, rate 0x04, control 0x08, transmit data 0x0C, status 0x10, FIFO control 0x18, count 0x1C, port 0x20 and line status 0x24. With fifo_mode_i high, writes to mode are ANDed with 0x7B and writes to control with 0xFB. With fifo_mode_i low, all eight bits are stored.
- R3: A control write with bit 5 (transmit enable) at 0 sets the transmit-end flag.
- R4: An accepted write to 0x0C stores the low byte and raises tx_valid_o with that byte on tx_data_o for exactly one cycle. It also clears the transmit-empty flag. In plain mode the stored byte reads back at 0x0C.
- R5: A status read places the flags at these bits: transmit end at bit 6, transmit empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0. All other bits are 0. A status write clears each of these flags whose bit is written 0 and leaves each flag whose bit is written 1 unchanged.
- R6: A status read while control bit 5 is 1 sets transmit-empty and transmit-end after the returned value is taken.
- R7: The count offset and the line-status offset read 0. Line-status writes are accepted and change nothing.
- R8: An access is unsupported if its offset is misaligned, is 0x14 or lies beyond the window, or is not supported in the current mode. Only 0x00 to 0x0C are supported in plain mode, and 0x0C cannot be read in FIFO mode. An unsupported access pulses err_o for one cycle and changes no state. If it is a read, it returns 0xFFFF.
- R9: FIFO control stores all 16 bits of wdata_i. The port register stores the low 8 bits.
- R10: When a read and a write hit the same offset in one cycle, the read returns the value after the write.
- R11: rdata_o and err_o change on the edge after the access. rdata_o holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects FIFO mode, 0 selects plain mode |
| addr_i | input | 6 | Byte offset of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| err_o | output | 1 | One-cycle pulse for an unsupported access |
| tx_valid_o | output | 1 | One-cycle pulse with each transmitted byte |
| tx_data_o | output | 8 | Transmitted byte |

## Verification
The bench checks the clear-on-zero semantics of the status register, with patterns that clear every flag and patterns that clear only transmit end. A design that cleared on one, or cleared every flag, would read back the wrong flag set.

It checks the read-side re-arm in two ways. A plain status read while transmit enable is high must return the cleared flags first and the set flags only on the next read. A combined read and write of the status register must return the value after the write. A design that applied the re-arm early would report set flags one read too soon.

It checks offsets that change meaning between the two modes, and checks that a rejected plain-mode write to FIFO control leaves the stored value intact. A design that let a rejected write through would corrupt that value.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [IDX_W-1:0] IDX_MODE  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_RATE  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_TXD   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_STAT  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_FCTL  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_CNT   = 4'd7;
  localparam logic [IDX_W-1:0] IDX_PORT  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_LSTAT = 4'd9;

  localparam int CTRL_TE_BIT = 5;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic rdy;
  } flags_t;
endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
  import sercfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fifo_mode_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              bad_o
);
  logic aligned, rd_sup, wr_sup;

  assign idx_o   = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    rd_sup = 1'b0;
    wr_sup = 1'b0;
    case (idx_o)
      IDX_MODE, IDX_RATE, IDX_CTRL: begin rd_sup = 1'b1; wr_sup = 1'b1; end
      IDX_TXD:  begin rd_sup = !fifo_mode_i; wr_sup = 1'b1; end
      IDX_STAT, IDX_FCTL, IDX_PORT, IDX_LSTAT: begin
        rd_sup = fifo_mode_i;
        wr_sup = fifo_mode_i;
      end
      IDX_CNT:  rd_sup = fifo_mode_i;
      default: ;
    endcase
  end

  assign bad_o   = (rd_i && !(aligned && rd_sup)) || (wr_i && !(aligned && wr_sup));
  assign rd_ok_o = rd_i && !bad_o;
  assign wr_ok_o = wr_i && !bad_o;
endmodule

// File: rtl/sercfg_bank.sv
module sercfg_bank
  import sercfg_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fifo_mode_i,
  input  logic                        wr_ok_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [4:0][BYTE_W-1:0]      byte_d_o,
  output logic [DATA_W-1:0]           fctl_d_o
);
  // slots: mode, rate, ctrl, txd, port
  localparam int NB = 5;
  localparam logic [IDX_W-1:0]  SLOT_IDX  [NB] = '{IDX_MODE, IDX_RATE, IDX_CTRL, IDX_TXD, IDX_PORT};
  localparam logic [BYTE_W-1:0] SLOT_RST  [NB] = '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00};
  localparam logic [BYTE_W-1:0] SLOT_FMSK [NB] = '{8'h7B, 8'hFF, 8'hFB, 8'hFF, 8'hFF};

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BYTE_W-1:0] q, d, msk;
    assign msk = fifo_mode_i ? SLOT_FMSK[g] : {BYTE_W{1'b1}};
    assign d   = (wr_ok_i && idx_i == SLOT_IDX[g]) ? (wdata_i[BYTE_W-1:0] & msk) : q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q <= SLOT_RST[g];
      else         q <= d;
    assign byte_d_o[g] = d;

    // R2
    mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok_i && fifo_mode_i && idx_i == SLOT_IDX[g]) |=> ((q & ~SLOT_FMSK[g]) == '0));
  end

  logic [DATA_W-1:0] fctl_q;
  assign fctl_d_o = (wr_ok_i && idx_i == IDX_FCTL) ? wdata_i : fctl_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fctl_q <= '0;
    else         fctl_q <= fctl_d_o;

  // R9
  fctl_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_i && idx_i == IDX_FCTL) |=> (fctl_q == $past(wdata_i)));
endmodule

// File: rtl/sercfg_flags.sv
module sercfg_flags
  import sercfg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_stat_i,
  input  flags_t keep_i,
  input  logic   set_tend_i,
  input  logic   clr_tde_i,
  input  logic   rearm_i,
  output flags_t flags_wr_o
);
  flags_t q, d;

  always_comb begin
    flags_wr_o = q;
    if (wr_stat_i) flags_wr_o = q & keep_i;
    if (set_tend_i) flags_wr_o.tend = 1'b1;
    if (clr_tde_i)  flags_wr_o.tde  = 1'b0;
    d = flags_wr_o;
    // re-arm lands after the read has sampled flags_wr_o
    if (rearm_i) begin
      d.tend = 1'b1;
      d.tde  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, rdy: 1'b0};
    else         q <= d;

  // R3
  tend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tend_i |=> q.tend);
  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !keep_i.tend && !set_tend_i && !rearm_i) |=> !q.tend);
  // R6
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (q.tend && q.tde));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat_i && !set_tend_i && !clr_tde_i && !rearm_i) |=> (q == $past(q)));
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic [IDX_W-1:0]       idx;
  logic                   rd_ok, wr_ok, bad;
  logic [4:0][BYTE_W-1:0] byte_d;
  logic [DATA_W-1:0]      fctl_d, rd_mux;
  flags_t                 flags_wr, keep;
  logic                   wr_ctrl, wr_txd;

  sercfg_decode u_dec (
    .addr_i(addr_i), .fifo_mode_i(fifo_mode_i), .rd_i(rd_i), .wr_i(wr_i),
    .idx_o(idx), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .bad_o(bad)
  );

  sercfg_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_mode_i(fifo_mode_i), .wr_ok_i(wr_ok),
    .idx_i(idx), .wdata_i(wdata_i), .byte_d_o(byte_d), .fctl_d_o(fctl_d)
  );

  assign wr_ctrl = wr_ok && idx == IDX_CTRL;
  assign wr_txd  = wr_ok && idx == IDX_TXD;
  assign keep    = '{tend: wdata_i[6], tde: wdata_i[5], brk: wdata_i[4],
                     rdf: wdata_i[1], rdy: wdata_i[0]};

  sercfg_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_stat_i(wr_ok && idx == IDX_STAT),
    .keep_i(keep),
    .set_tend_i(wr_ctrl && !wdata_i[CTRL_TE_BIT]),
    .clr_tde_i(wr_txd),
    .rearm_i(rd_ok && idx == IDX_STAT && byte_d[2][CTRL_TE_BIT]),
    .flags_wr_o(flags_wr)
  );

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_MODE: rd_mux[BYTE_W-1:0] = byte_d[0];
      IDX_RATE: rd_mux[BYTE_W-1:0] = byte_d[1];
      IDX_CTRL: rd_mux[BYTE_W-1:0] = byte_d[2];
      IDX_TXD:  rd_mux[BYTE_W-1:0] = byte_d[3];
      IDX_PORT: rd_mux[BYTE_W-1:0] = byte_d[4];
      IDX_FCTL: rd_mux = fctl_d;
      IDX_STAT: rd_mux[6:0] = {flags_wr.tend, flags_wr.tde, flags_wr.brk, 2'b00,
                               flags_wr.rdf, flags_wr.rdy};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_o    <= '0;
      err_o      <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      if (rd_i) rdata_o <= bad ? {DATA_W{1'b1}} : rd_mux;
      err_o      <= bad;
      tx_valid_o <= wr_txd;
      if (wr_txd) tx_data_o <= wdata_i[BYTE_W-1:0];
    end

  // R4
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !bad && addr_i == ADDR_W'(8'h0C)) |=> (tx_valid_o && tx_data_o == $past(wdata_i[BYTE_W-1:0])));
  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && bad) |=> (err_o && rdata_o == {DATA_W{1'b1}}));
  // R7
  cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && (idx == IDX_CNT || idx == IDX_LSTAT)) |=> (rdata_o == '0));
  // R5
  stat_resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && idx == IDX_STAT) |=> (rdata_o[DATA_W-1:7] == '0 && rdata_o[3:2] == 2'b00));
  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_sercfg_regs.sv
`timescale 1ns/1ps
module tb_sercfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b1;
  logic [5:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err, tx_valid;
  logic [7:0]  tx_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sercfg_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_mode_i(fifo_mode), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  typedef struct packed {
    logic        fifo;
    logic        rd;
    logic        wr;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    logic        exp_err;
    logic        exp_tx;
    logic [7:0]  exp_txd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,6'h04,16'h0000,16'h00FF,1'b0,1'b0,8'h00,4'd1},  // R1
    '{1'b1,1'b1,1'b0,6'h00,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd1},  // R1
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0060,1'b0,1'b0,8'h00,4'd1},  // R1
    '{1'b1,1'b0,1'b1,6'h00,16'h00FF,16'h0000,1'b0,1'b0,8'h00,4'd2},  // R2
    '{1'b1,1'b1,1'b0,6'h00,16'h0000,16'h007B,1'b0,1'b0,8'h00,4'd2},  // R2
    '{1'b1,1'b0,1'b1,6'h08,16'h00FF,16'h0000,1'b0,1'b0,8'h00,4'd2},
    '{1'b1,1'b1,1'b0,6'h08,16'h0000,16'h00FB,1'b0,1'b0,8'h00,4'd2},
    '{1'b1,1'b0,1'b1,6'h10,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd5},  // R5
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd5},
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0060,1'b0,1'b0,8'h00,4'd6},  // R6
    '{1'b1,1'b0,1'b1,6'h08,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd3},  // R3
    '{1'b1,1'b0,1'b1,6'h10,16'h00BF,16'h0000,1'b0,1'b0,8'h00,4'd5},
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0020,1'b0,1'b0,8'h00,4'd5},
    '{1'b1,1'b0,1'b1,6'h08,16'h0010,16'h0000,1'b0,1'b0,8'h00,4'd3},
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0060,1'b0,1'b0,8'h00,4'd3},
    '{1'b1,1'b0,1'b1,6'h0C,16'h00A5,16'h0000,1'b0,1'b1,8'hA5,4'd4},  // R4
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0040,1'b0,1'b0,8'h00,4'd4},
    '{1'b1,1'b0,1'b1,6'h18,16'hABCD,16'h0000,1'b0,1'b0,8'h00,4'd9},  // R9
    '{1'b1,1'b1,1'b0,6'h18,16'h0000,16'hABCD,1'b0,1'b0,8'h00,4'd9},
    '{1'b1,1'b0,1'b1,6'h20,16'h1234,16'h0000,1'b0,1'b0,8'h00,4'd9},
    '{1'b1,1'b1,1'b0,6'h20,16'h0000,16'h0034,1'b0,1'b0,8'h00,4'd9},
    '{1'b1,1'b1,1'b0,6'h1C,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd7},  // R7
    '{1'b1,1'b0,1'b1,6'h24,16'hFFFF,16'h0000,1'b0,1'b0,8'h00,4'd7},
    '{1'b1,1'b1,1'b0,6'h24,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd7},
    '{1'b1,1'b0,1'b1,6'h1C,16'h0005,16'h0000,1'b1,1'b0,8'h00,4'd8},  // R8
    '{1'b1,1'b1,1'b0,6'h14,16'h0000,16'hFFFF,1'b1,1'b0,8'h00,4'd8},
    '{1'b1,1'b1,1'b0,6'h0C,16'h0000,16'hFFFF,1'b1,1'b0,8'h00,4'd8},
    '{1'b1,1'b1,1'b0,6'h02,16'h0000,16'hFFFF,1'b1,1'b0,8'h00,4'd8},
    '{1'b1,1'b1,1'b1,6'h04,16'h003C,16'h003C,1'b0,1'b0,8'h00,4'd10}, // R10
    '{1'b1,1'b1,1'b1,6'h10,16'h0000,16'h0000,1'b0,1'b0,8'h00,4'd10},
    '{1'b1,1'b0,1'b1,6'h08,16'h0020,16'h0000,1'b0,1'b0,8'h00,4'd6},
    '{1'b1,1'b1,1'b1,6'h10,16'h00FF,16'h0000,1'b0,1'b0,8'h00,4'd6},
    '{1'b1,1'b1,1'b0,6'h10,16'h0000,16'h0060,1'b0,1'b0,8'h00,4'd6},
    '{1'b0,1'b0,1'b1,6'h00,16'h00FF,16'h0000,1'b0,1'b0,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,6'h00,16'h0000,16'h00FF,1'b0,1'b0,8'h00,4'd2},
    '{1'b0,1'b0,1'b1,6'h08,16'h00FF,16'h0000,1'b0,1'b0,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,6'h08,16'h0000,16'h00FF,1'b0,1'b0,8'h00,4'd2},
    '{1'b0,1'b1,1'b0,6'h0C,16'h0000,16'h00A5,1'b0,1'b0,8'h00,4'd4},
    '{1'b0,1'b1,1'b0,6'h10,16'h0000,16'hFFFF,1'b1,1'b0,8'h00,4'd8},
    '{1'b0,1'b0,1'b1,6'h18,16'h1111,16'h0000,1'b1,1'b0,8'h00,4'd8},
    '{1'b0,1'b1,1'b0,6'h18,16'h0000,16'hFFFF,1'b1,1'b0,8'h00,4'd8},
    '{1'b0,1'b0,1'b1,6'h0C,16'h005A,16'h0000,1'b0,1'b1,8'h5A,4'd4},
    '{1'b0,1'b1,1'b0,6'h0C,16'h0000,16'h005A,1'b0,1'b0,8'h00,4'd4},
    '{1'b1,1'b1,1'b0,6'h18,16'h0000,16'hABCD,1'b0,1'b0,8'h00,4'd8}
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic f, input logic r, input logic w, input logic [5:0] a, input logic [15:0] d);
    fifo_mode = f; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check(1, "rdata after reset", rdata, 16'h0000);
    check(1, "err after reset", {15'd0, err}, 16'h0000);
    check(1, "tx_valid after reset", {15'd0, tx_valid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].fifo, VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wd);
      if (VECS[i].rd) check(VECS[i].req, $sformatf("vec %0d rdata", i), rdata, VECS[i].exp_rd);
      check(VECS[i].req, $sformatf("vec %0d err", i), {15'd0, err}, {15'd0, VECS[i].exp_err});
      check(VECS[i].req, $sformatf("vec %0d tx_valid", i), {15'd0, tx_valid}, {15'd0, VECS[i].exp_tx});
      if (VECS[i].exp_tx) check(VECS[i].req, $sformatf("vec %0d tx_data", i), {8'd0, tx_data}, {8'd0, VECS[i].exp_txd});
    end

    // R11 read data holds through idle cycles, error pulse ends
    access(1'b1, 1'b1, 1'b0, 6'h04, 16'h0);
    check(11, "rate read", rdata, 16'h003C);
    access(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
    access(1'b1, 1'b0, 1'b1, 6'h14, 16'h0);
    check(11, "err pulse", {15'd0, err}, 16'h0001);
    access(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
    check(11, "rdata held", rdata, 16'h003C);
    check(8, "err one cycle", {15'd0, err}, 16'h0000);

    // R1 second reset: data register and mode back to reset values
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b1, 1'b0, 6'h0C, 16'h0);
    check(1, "data reg reset", rdata, 16'h00FF);
    access(1'b0, 1'b1, 1'b0, 6'h00, 16'h0);
    check(1, "mode reset", rdata, 16'h0000);
    access(1'b1, 1'b1, 1'b0, 6'h18, 16'h0);
    check(1, "fifo ctrl reset", rdata, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule